// File: doc/BRIEF.md
# Service-Timeout Watchdog with Split Prescaler

This block watches for software that has stopped making progress. A free-running chain of 18 bits counts every clock cycle. The lower 12 bits of the chain form a prescaler, and the upper 6 bits form the watchdog counter. If the chain reaches the end of the selected period, the block raises a one-cycle reset request for the reset sequencer. A rate-select input chooses between two period lengths. Both lengths use the same chain: the long period ends at the carry out of the whole chain, and the short period ends at the carry into bit 13.

Software keeps the block quiet by writing to the decoded service address. A service write clears the counter and the prescaler stages above the lowest four. The lowest four stages keep running, so the timeout after a service is known only to within 16 cycles. A reset-vector fetch, a stop instruction and any internal reset source clear the chain in the same way. A global disable suppresses the request and holds the chain at zero.

Top module: `wdog_timer`

## Requirements
- R1: After the synchronous reset `rst`, `timeout_rst` is low and the whole chain is zero. The first request comes exactly 2^T cycles after `rst` is released, where T is the length of the selected period.
- R2: With `rate_short`=0, T equals the full chain width (18 by default). If nothing services the block, `timeout_rst` goes high 2^18 cycles after the last full restart.
- R3: With `rate_short`=1, T equals SHORT_TAP (13 by default). The request fires when the low SHORT_TAP bits of the chain are all ones.
- R4: `timeout_rst` stays high for exactly one cycle. In the same cycle the whole chain restarts from zero, so the next request comes one full period 2^T later.
- R5: A cycle with `svc_wr` high clears the counter and the prescaler bits at KEEP_LSB (4) and above. The low KEEP_LSB bits keep counting. If the service is applied while the chain holds the value e, the next request comes 2^T − ((e+1) mod 2^KEEP_LSB) cycles after that edge, which always lies between 2^T−2^KEEP_LSB and 2^T.
- R6: `vec_fetch`, `stop_req` and `int_rst` each clear the chain exactly as `svc_wr` does.
- R7: If a clearing strobe is high in the same cycle that the chain would overflow, no request is issued. The following request then comes 2^T cycles later.
- R8: While `wd_disable` is high, no request is issued and the whole chain is held at zero. After `wd_disable` falls, the first request comes exactly 2^T cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; the chain advances on every rising edge |
| rst | input | 1 | Synchronous active-high power-up reset |
| wd_disable | input | 1 | Global disable: no request, chain held at zero |
| rate_short | input | 1 | 1 selects the 2^SHORT_TAP period, 0 selects the full-chain period |
| svc_wr | input | 1 | Decoded strobe for a write of any data value to the service address |
| vec_fetch | input | 1 | Reset-vector fetch strobe |
| stop_req | input | 1 | Stop-instruction strobe |
| int_rst | input | 1 | An internal reset source is active |
| timeout_rst | output | 1 | Registered one-cycle reset request |

## Verification
The request is registered, so it appears right after the edge at which the chain held the last value of its period. After any restart, that is 2^T edges later. After a service applied at chain value e, it is 2^T−((e+1) mod 16) edges later. The bench applies each strobe for exactly one edge. It then counts edges up to and including the first edge after which `timeout_rst` reads high. All reads happen one time unit after the edge. The bench checks that count against the formula, and it checks that the output is low again one edge later. The bench uses a reduced chain (8+4 bits, short tap 9), so it can sweep many service phases and still cover the collision with overflow and the long period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_SOFT = 2'd1,
    CLR_HARD = 2'd2
  } clr_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int PRE_W    = 12,
  parameter int KEEP_LSB = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  clr_e             clr_kind,
  output logic [PRE_W-1:0] pre_q,
  output logic             carry
);
  localparam int UP_W = PRE_W - KEEP_LSB;

  logic [KEEP_LSB-1:0] low_q;
  logic [UP_W-1:0]     up_q;
  logic                low_wrap;

  assign low_wrap = &low_q;

  // Low stages: only a hard clear stops them.
  always_ff @(posedge clk) begin
    if (rst || clr_kind == CLR_HARD) begin
      low_q <= '0;
    end else begin
      low_q <= low_q + KEEP_LSB'(1);
    end
  end

  // Upper stages: cleared by soft and hard clears.
  always_ff @(posedge clk) begin
    if (rst || clr_kind != CLR_NONE) begin
      up_q <= '0;
    end else if (low_wrap) begin
      up_q <= up_q + UP_W'(1);
    end
  end

  assign pre_q = {up_q, low_q};
  assign carry = &pre_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdog_tap.sv
module wdog_tap #(
  parameter int CHAIN_W   = 18,
  parameter int SHORT_TAP = 13
) (
  input  logic [CHAIN_W-1:0] chain,
  input  logic               rate_short,
  output logic               hit
);
  logic long_hit;
  logic short_hit;

  assign long_hit = &chain;

  generate
    if (SHORT_TAP < CHAIN_W) begin : g_tap
      assign short_hit = &chain[SHORT_TAP-1:0];
    end else begin : g_no_tap
      assign short_hit = long_hit;
    end
  endgenerate

  assign hit = rate_short ? short_hit : long_hit;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRE_W     = 12,
  parameter int CNT_W     = 6,
  parameter int SHORT_TAP = 13,
  parameter int KEEP_LSB  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wd_disable,
  input  logic rate_short,
  input  logic svc_wr,
  input  logic vec_fetch,
  input  logic stop_req,
  input  logic int_rst,
  output logic timeout_rst
);
  localparam int CHAIN_W = PRE_W + CNT_W;

  logic [PRE_W-1:0]   pre_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CHAIN_W-1:0] chain;
  logic               pre_carry;
  logic               hit;
  logic               svc_any;
  logic               fire;
  clr_e               clr_kind;

  assign chain   = {cnt_q, pre_q};
  assign svc_any = svc_wr | vec_fetch | stop_req | int_rst;
  assign fire    = hit & ~svc_any & ~wd_disable;

  always_comb begin
    if (wd_disable || fire) begin
      clr_kind = CLR_HARD;
    end else if (svc_any) begin
      clr_kind = CLR_SOFT;
    end else begin
      clr_kind = CLR_NONE;
    end
  end

  wdog_prescaler #(
    .PRE_W   (PRE_W),
    .KEEP_LSB(KEEP_LSB)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clr_kind(clr_kind),
    .pre_q   (pre_q),
    .carry   (pre_carry)
  );

  wdog_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_kind != CLR_NONE),
    .inc  (pre_carry),
    .cnt_q(cnt_q)
  );

  wdog_tap #(
    .CHAIN_W  (CHAIN_W),
    .SHORT_TAP(SHORT_TAP)
  ) u_tap (
    .chain     (chain),
    .rate_short(rate_short),
    .hit       (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_rst <= 1'b0;
    end else begin
      timeout_rst <= fire;
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CHAIN_W  = 18,
  parameter int KEEP_LSB = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wd_disable,
  input logic               svc_wr,
  input logic               vec_fetch,
  input logic               stop_req,
  input logic               int_rst,
  input logic [CHAIN_W-1:0] chain,
  input logic               timeout_rst
);
  logic                strobe;
  logic [KEEP_LSB-1:0] low_inc_q;

  assign strobe = svc_wr | vec_fetch | stop_req | int_rst;

  always_ff @(posedge clk) begin
    low_inc_q <= chain[KEEP_LSB-1:0] + KEEP_LSB'(1);
  end

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    timeout_rst |=> !timeout_rst);

  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    timeout_rst |-> chain == '0);

  a_r7_service_wins: assert property (@(posedge clk) disable iff (rst)
    $past(strobe) |-> !timeout_rst);

  a_r8_no_request: assert property (@(posedge clk) disable iff (rst)
    $past(wd_disable) |-> !timeout_rst);

  a_r8_held_zero: assert property (@(posedge clk) disable iff (rst)
    $past(wd_disable) |-> chain == '0);

  a_r5_low_runs: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(strobe) && !$past(wd_disable))
      |-> (chain[KEEP_LSB-1:0] == low_inc_q &&
           chain[CHAIN_W-1:KEEP_LSB] == '0));
endmodule

bind wdog_timer wdog_checker #(
  .CHAIN_W (CHAIN_W),
  .KEEP_LSB(KEEP_LSB)
) u_wdog_chk (
  .clk        (clk),
  .rst        (rst),
  .wd_disable (wd_disable),
  .svc_wr     (svc_wr),
  .vec_fetch  (vec_fetch),
  .stop_req   (stop_req),
  .int_rst    (int_rst),
  .chain      (chain),
  .timeout_rst(timeout_rst)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CLK_P     = 10;
  localparam int PRE_W     = 8;
  localparam int CNT_W     = 4;
  localparam int SHORT_TAP = 9;
  localparam int KEEP_LSB  = 4;
  localparam int LONG_P    = 1 << (PRE_W + CNT_W);
  localparam int SHORT_P   = 1 << SHORT_TAP;
  localparam int LOW_M     = 1 << KEEP_LSB;
  localparam int WD_LIMIT  = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_disable = 1'b0;
  logic rate_short = 1'b0;
  logic svc_wr = 1'b0;
  logic vec_fetch = 1'b0;
  logic stop_req = 1'b0;
  logic int_rst = 1'b0;
  logic timeout_rst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  wdog_timer #(
    .PRE_W    (PRE_W),
    .CNT_W    (CNT_W),
    .SHORT_TAP(SHORT_TAP),
    .KEEP_LSB (KEEP_LSB)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .wd_disable (wd_disable),
    .rate_short (rate_short),
    .svc_wr     (svc_wr),
    .vec_fetch  (vec_fetch),
    .stop_req   (stop_req),
    .int_rst    (int_rst),
    .timeout_rst(timeout_rst)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: cycles=%0d expected <= %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic short_sel);
    rst = 1'b1;
    rate_short = short_sel;
    wd_disable = 1'b0;
    svc_wr = 1'b0; vec_fetch = 1'b0; stop_req = 1'b0; int_rst = 1'b0;
    tick(); tick(); tick();
    rst = 1'b0;
  endtask

  // Edges until timeout_rst reads high (0 if none within lim).
  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (timeout_rst) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic run_ticks(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  int n;
  int cnt_hi;

  initial begin
    // R1/R2: reset state and first long-period request
    do_reset(1'b0);
    check("R1 reset output", int'(timeout_rst), 0);
    wait_pulse(LONG_P + 8, n);
    check("R2 long period from reset", n, LONG_P);
    tick();
    check("R4 pulse one cycle", int'(timeout_rst), 0);
    wait_pulse(LONG_P + 8, n);
    check("R4 full restart after pulse", n, LONG_P - 1);

    // R3: short period
    do_reset(1'b1);
    wait_pulse(SHORT_P + 8, n);
    check("R3 short period from reset", n, SHORT_P);
    tick();
    check("R4 short pulse one cycle", int'(timeout_rst), 0);

    // R5: service phase sweep, short period
    for (int e = 0; e < 40; e++) begin
      do_reset(1'b1);
      run_ticks(e);
      svc_wr = 1'b1;
      tick();
      svc_wr = 1'b0;
      wait_pulse(SHORT_P + 8, n);
      check("R5 service sweep", n, SHORT_P - ((e + 1) % LOW_M));
    end

    // R5: service in long mode
    do_reset(1'b0);
    run_ticks(100);
    svc_wr = 1'b1;
    tick();
    svc_wr = 1'b0;
    wait_pulse(LONG_P + 8, n);
    check("R5 long service", n, LONG_P - (101 % LOW_M));

    // R6: other clearing strobes
    for (int s = 0; s < 3; s++) begin
      do_reset(1'b1);
      run_ticks(20);
      if (s == 0) vec_fetch = 1'b1;
      if (s == 1) stop_req = 1'b1;
      if (s == 2) int_rst = 1'b1;
      tick();
      vec_fetch = 1'b0; stop_req = 1'b0; int_rst = 1'b0;
      wait_pulse(SHORT_P + 8, n);
      check("R6 alternate clear source", n, SHORT_P - (21 % LOW_M));
    end

    // R7: service collides with overflow
    do_reset(1'b1);
    run_ticks(SHORT_P - 1);
    svc_wr = 1'b1;
    tick();
    svc_wr = 1'b0;
    check("R7 no request on collision", int'(timeout_rst), 0);
    wait_pulse(SHORT_P + 8, n);
    check("R7 period after collision", n, SHORT_P);

    // R8: disable holds off requests
    do_reset(1'b1);
    wd_disable = 1'b1;
    cnt_hi = 0;
    for (int i = 0; i < 4 * SHORT_P; i++) begin
      tick();
      if (timeout_rst) cnt_hi++;
    end
    check("R8 no request while disabled", cnt_hi, 0);
    wd_disable = 1'b0;
    wait_pulse(SHORT_P + 8, n);
    check("R8 full period after enable", n, SHORT_P);

    // R8: disable applied at the overflow cycle
    do_reset(1'b1);
    run_ticks(SHORT_P - 1);
    wd_disable = 1'b1;
    tick();
    check("R8 disable at overflow", int'(timeout_rst), 0);
    wd_disable = 1'b0;
    wait_pulse(SHORT_P + 8, n);
    check("R8 period after late disable", n, SHORT_P);

    summary();
  end
endmodule